// File: doc/BRIEF.md
# Zero-Crossing Windowed Energy Integrator

The block sums unsigned apparent-power samples over a window made of a programmable number of line half-cycles. It does not count clock cycles to find the window end. It counts zero-crossing pulses from an upstream detector. When the last crossing of a window arrives, the block divides the window total by an 8-bit scale factor and holds the low 24 bits of the quotient in a result register. It also raises a sticky cycle-end flag. The flag drives an active-low interrupt that can be masked.

Accumulation is always running and has no enable bit. Upstream logic supplies one valid power word every four clocks, together with the crossing pulses. The result register keeps its value for the whole of the next window. Because every window spans the same whole number of half-cycles, results from different windows can be compared directly.

Top module: `line_energy_acc`

## Requirements
- R1: While and after reset, before any window closes, `energy_o` is 0, `cyc_flag_o` is 0 and `irq_no` is 1.
- R2: A window closes on the clock where the N-th zero-crossing pulse of that window is seen. N is `half_cyc_i`. `energy_o` changes only on the clock after a window close and holds its value at all other times.
- R3: After a close, `energy_o` equals bits [23:0] of (window sum / D). D is `div_i`, and a value of 0 is used as 1. The sum is taken modulo 2^48.
- R4: A `half_cyc_i` of 0 is treated as 1, so every crossing pulse closes a window.
- R5: A sample whose strobe falls on the same clock as the closing crossing counts in the window that closes. The next window starts from zero, so no sample is lost or counted twice.
- R6: When the scaled total is 2^24 or more, only its low 24 bits appear on `energy_o`.
- R7: `cyc_flag_o` rises on the clock after a window close. It stays set until a `flag_clr_i` pulse arrives. If a close and a clear fall on the same clock, the set wins.
- R8: `irq_no` is low exactly when `cyc_flag_o` is 1 and `cyc_mask_i` is 1. With the mask at 0 the line stays high.
- R9: A power word presented while `smp_vld_i` is 0 does not change any result.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| smp_vld_i | input | 1 | Power sample valid strobe |
| smp_pwr_i | input | 24 | Unsigned apparent-power sample |
| zx_i | input | 1 | Zero-crossing pulse, one clock wide |
| half_cyc_i | input | 16 | Half-cycles per window (0 acts as 1) |
| div_i | input | 8 | Result divisor (0 acts as 1) |
| cyc_mask_i | input | 1 | Interrupt enable for the cycle-end flag |
| flag_clr_i | input | 1 | Clears the cycle-end flag |
| energy_o | output | 24 | Latched energy of the last window |
| cyc_flag_o | output | 1 | Sticky cycle-end flag |
| irq_no | output | 1 | Interrupt, active low |

## Verification
The hardest case to reach is a sample strobe and the closing crossing on the same clock, because the sample must land in the old window and not in the new one. The stimulus runs the sample strobe on a four-clock grid. It places crossings at phases that land on the grid for some windows and between grid points for others. A behavioural model in the bench tracks window membership, and the design is compared against it on every clock. Further runs drive large samples into long windows with a divisor of 1 to push the quotient past 24 bits. They also pulse a clear on the same clock as a close.

// File: rtl/lea_pkg.sv
package lea_pkg;
  localparam int unsigned PWR_W_DEF = 24;
  localparam int unsigned ACC_W_DEF = 48;
  localparam int unsigned OUT_W_DEF = 24;
  localparam int unsigned CNT_W_DEF = 16;
  localparam int unsigned DIV_W_DEF = 8;
endpackage

// File: rtl/zx_window_ctr.sv
module zx_window_ctr #(
  parameter int unsigned CNT_W = lea_pkg::CNT_W_DEF
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             zx_i,
  input  logic [CNT_W-1:0] half_cyc_i,
  output logic             win_end_o
);
  logic [CNT_W-1:0] seen_q;
  logic [CNT_W-1:0] limit;
  logic [CNT_W:0]   seen_nxt;

  // a zero count still closes on every crossing
  assign limit     = (half_cyc_i == '0) ? CNT_W'(1) : half_cyc_i;
  assign seen_nxt  = {1'b0, seen_q} + (CNT_W+1)'(1);
  assign win_end_o = zx_i && (seen_nxt >= {1'b0, limit});

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)        seen_q <= '0;
    else if (win_end_o) seen_q <= '0;
    else if (zx_i)      seen_q <= seen_nxt[CNT_W-1:0];
  end
endmodule

// File: rtl/energy_integrator.sv
module energy_integrator #(
  parameter int unsigned PWR_W = lea_pkg::PWR_W_DEF,
  parameter int unsigned ACC_W = lea_pkg::ACC_W_DEF
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             smp_vld_i,
  input  logic [PWR_W-1:0] smp_pwr_i,
  input  logic             win_end_i,
  output logic [ACC_W-1:0] total_o
);
  localparam int unsigned PAD_W = ACC_W - PWR_W;
  logic [ACC_W-1:0] acc_q;
  logic [ACC_W-1:0] addend;

  assign addend  = smp_vld_i ? {{PAD_W{1'b0}}, smp_pwr_i} : '0;
  // same-cycle sample belongs to the closing window
  assign total_o = acc_q + addend;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)        acc_q <= '0;
    else if (win_end_i) acc_q <= '0;
    else                acc_q <= total_o;
  end
endmodule

// File: rtl/energy_scaler.sv
module energy_scaler #(
  parameter int unsigned ACC_W = lea_pkg::ACC_W_DEF,
  parameter int unsigned DIV_W = lea_pkg::DIV_W_DEF,
  parameter int unsigned OUT_W = lea_pkg::OUT_W_DEF
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             win_end_i,
  input  logic [ACC_W-1:0] total_i,
  input  logic [DIV_W-1:0] div_i,
  output logic [OUT_W-1:0] energy_o
);
  localparam int unsigned PAD_W = ACC_W - DIV_W;
  logic [DIV_W-1:0] div_eff;
  logic [ACC_W-1:0] quot;

  assign div_eff = (div_i == '0) ? DIV_W'(1) : div_i;
  assign quot    = total_i / {{PAD_W{1'b0}}, div_eff};

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)        energy_o <= '0;
    else if (win_end_i) energy_o <= quot[OUT_W-1:0];
  end
endmodule

// File: rtl/cyc_status.sv
module cyc_status (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic win_end_i,
  input  logic flag_clr_i,
  input  logic cyc_mask_i,
  output logic cyc_flag_o,
  output logic irq_no
);
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)         cyc_flag_o <= 1'b0;
    else if (win_end_i)  cyc_flag_o <= 1'b1;
    else if (flag_clr_i) cyc_flag_o <= 1'b0;
  end

  assign irq_no = ~(cyc_flag_o & cyc_mask_i);
endmodule

// File: rtl/line_energy_acc.sv
module line_energy_acc #(
  parameter int unsigned PWR_W = lea_pkg::PWR_W_DEF,
  parameter int unsigned ACC_W = lea_pkg::ACC_W_DEF,
  parameter int unsigned OUT_W = lea_pkg::OUT_W_DEF,
  parameter int unsigned CNT_W = lea_pkg::CNT_W_DEF,
  parameter int unsigned DIV_W = lea_pkg::DIV_W_DEF
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             smp_vld_i,
  input  logic [PWR_W-1:0] smp_pwr_i,
  input  logic             zx_i,
  input  logic [CNT_W-1:0] half_cyc_i,
  input  logic [DIV_W-1:0] div_i,
  input  logic             cyc_mask_i,
  input  logic             flag_clr_i,
  output logic [OUT_W-1:0] energy_o,
  output logic             cyc_flag_o,
  output logic             irq_no
);
  logic             win_end;
  logic [ACC_W-1:0] total;

  zx_window_ctr #(.CNT_W(CNT_W)) u_ctr (
    .clk_i, .rst_ni, .zx_i, .half_cyc_i, .win_end_o(win_end)
  );

  energy_integrator #(.PWR_W(PWR_W), .ACC_W(ACC_W)) u_int (
    .clk_i, .rst_ni, .smp_vld_i, .smp_pwr_i, .win_end_i(win_end), .total_o(total)
  );

  energy_scaler #(.ACC_W(ACC_W), .DIV_W(DIV_W), .OUT_W(OUT_W)) u_scl (
    .clk_i, .rst_ni, .win_end_i(win_end), .total_i(total), .div_i, .energy_o
  );

  cyc_status u_sts (
    .clk_i, .rst_ni, .win_end_i(win_end), .flag_clr_i, .cyc_mask_i, .cyc_flag_o, .irq_no
  );
endmodule

// File: rtl/line_energy_chk.sv
module line_energy_chk #(
  parameter int unsigned OUT_W = lea_pkg::OUT_W_DEF
) (
  input logic             clk_i,
  input logic             rst_ni,
  input logic             zx_i,
  input logic             win_end_i,
  input logic             cyc_mask_i,
  input logic             flag_clr_i,
  input logic [OUT_W-1:0] energy_o,
  input logic             cyc_flag_o,
  input logic             irq_no
);
  // R2
  energy_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !win_end_i |=> $stable(energy_o));
  // R2
  close_needs_zx_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    win_end_i |-> zx_i);
  // R7
  flag_set_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    win_end_i |=> cyc_flag_o);
  // R7
  flag_sticky_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cyc_flag_o && !flag_clr_i) |=> cyc_flag_o);
  // R7
  flag_rise_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(cyc_flag_o) |-> $past(win_end_i));
  // R8
  irq_fall_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(irq_no) |-> (cyc_flag_o && cyc_mask_i));
  // R8
  irq_masked_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !cyc_mask_i |-> irq_no);
endmodule

bind line_energy_acc line_energy_chk #(.OUT_W(OUT_W)) u_chk (
  .clk_i(clk_i), .rst_ni(rst_ni), .zx_i(zx_i), .win_end_i(win_end),
  .cyc_mask_i(cyc_mask_i), .flag_clr_i(flag_clr_i), .energy_o(energy_o),
  .cyc_flag_o(cyc_flag_o), .irq_no(irq_no)
);

// File: tb/sim_line_energy_acc.sv
`timescale 1ns/1ps
module sim_line_energy_acc;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        vld = 1'b0;
  logic [23:0] pwr = '0;
  logic        zx = 1'b0;
  logic [15:0] half = 16'd1;
  logic [7:0]  dv = 8'd0;
  logic        mask = 1'b0;
  logic        clr = 1'b0;
  logic [23:0] energy;
  logic        flag;
  logic        irq_n;

  int tests = 0;
  int fails = 0;

  always #2.5 clk = ~clk;

  line_energy_acc u0 (
    .clk_i(clk), .rst_ni(rst_n), .smp_vld_i(vld), .smp_pwr_i(pwr), .zx_i(zx),
    .half_cyc_i(half), .div_i(dv), .cyc_mask_i(mask), .flag_clr_i(clr),
    .energy_o(energy), .cyc_flag_o(flag), .irq_no(irq_n)
  );

  // behavioural reference
  longint unsigned m_acc;
  int unsigned     m_seen;
  longint unsigned m_energy;
  bit              m_flag;
  int              m_closes;
  localparam longint unsigned MASK48 = (64'd1 << 48) - 64'd1;

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m_acc = 0; m_seen = 0; m_energy = 0; m_flag = 0; m_closes = 0;
    end else begin
      longint unsigned tot;
      int unsigned n;
      longint unsigned d;
      bit close;
      tot = (m_acc + (vld ? longint'(pwr) : 64'd0)) & MASK48;
      n = (half == 0) ? 1 : half;
      d = (dv == 0) ? 1 : dv;
      close = 0;
      if (zx) begin
        m_seen++;
        if (m_seen >= n) begin close = 1; m_seen = 0; end
      end
      if (close) begin
        m_energy = (tot / d) & 64'hFF_FFFF;
        m_acc = 0;
        m_closes++;
      end else m_acc = tot;
      if (close) m_flag = 1;
      else if (clr) m_flag = 0;
    end
  end

  task automatic compare(string tag);
    bit exp_irq;
    exp_irq = !(m_flag && mask);
    tests++;
    if (energy !== m_energy[23:0]) begin
      fails++;
      $display("FAIL %s energy act=%h exp=%h", tag, energy, m_energy[23:0]);
    end
    tests++;
    if (flag !== m_flag) begin
      fails++;
      $display("FAIL R7 %s flag act=%b exp=%b", tag, flag, m_flag);
    end
    tests++;
    if (irq_n !== exp_irq) begin
      fails++;
      $display("FAIL R8 %s irq_n act=%b exp=%b", tag, irq_n, exp_irq);
    end
  endtask

  // one clock: check previous result, then drive new inputs
  task automatic step(string tag, bit v, logic [23:0] p, bit z, bit c);
    @(negedge clk);
    compare(tag);
    vld = v; pwr = p; zx = z; clr = c;
  endtask

  // samples every 4 clocks, crossings every zp clocks at phase zph
  task automatic run(string tag, int cycles, int zp, int zph, int seed, bit big);
    for (int c = 0; c < cycles; c++) begin
      bit v;
      logic [23:0] p;
      v = (c % 4) == 0;
      p = big ? 24'hFFFFFF - 24'(c % 7) : 24'((c * 37 + seed) % 5000);
      // R9: junk data while strobe low
      if (!v) p = 24'hABCDEF;
      step(tag, v, p, (c % zp) == zph, 1'b0);
    end
  endtask

  initial begin
    #100000000;
    fails++;
    $display("FAIL watchdog expired");
    $display("  [TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    // R1 reset values
    tests++;
    if (energy !== 24'd0 || flag !== 1'b0 || irq_n !== 1'b1) begin
      fails++;
      $display("FAIL R1 act=%h/%b/%b exp=0/0/1", energy, flag, irq_n);
    end
    rst_n = 1'b1;
    mask = 1'b1;
    step("R1", 0, 0, 0, 0);
    step("R1", 0, 0, 0, 0);

    // R2 R3 R5: 3 half-cycles, crossings on the sample grid
    half = 16'd3; dv = 8'd0;
    run("R2 R5", 600, 40, 0, 11, 0);
    // crossings off the sample grid
    run("R2 R3", 600, 38, 3, 5, 0);
    // R3 divisor
    dv = 8'd7;
    run("R3", 500, 36, 8, 2, 0);
    step("R7", 0, 0, 0, 1);
    step("R7", 0, 0, 0, 0);
    // R4: zero count
    half = 16'd0; dv = 8'd3;
    run("R4", 300, 20, 4, 9, 0);
    // R8: masked
    mask = 1'b0;
    run("R8", 200, 24, 1, 3, 0);
    step("R8", 0, 0, 0, 1);
    mask = 1'b1;
    step("R8", 0, 0, 0, 0);
    step("R8", 0, 0, 0, 0);
    // R6: overflow of the 24-bit result
    half = 16'd1; dv = 8'd1;
    run("R6", 2000, 1200, 8, 0, 1);
    dv = 8'd200;
    run("R6 R3", 2000, 1600, 12, 0, 1);
    // R7: clear on the same clock as a close, set wins
    half = 16'd2; dv = 8'd0;
    run("R7", 40, 100, 99, 1, 0);
    step("R7", 1, 24'd50, 1, 1);
    step("R7", 1, 24'd60, 1, 1);
    step("R7", 0, 0, 0, 0);
    step("R7", 0, 0, 0, 1);
    step("R7", 0, 0, 0, 0);
    // R9: junk data only, a close must give zero
    half = 16'd1;
    for (int c = 0; c < 30; c++) step("R9", 0, 24'hFFFFFF, c == 29, 0);
    step("R9", 0, 0, 0, 0);
    tests++;
    if (energy !== 24'd0) begin
      fails++;
      $display("FAIL R9 energy act=%h exp=000000", energy);
    end
    tests++;
    if (m_closes < 20) begin
      fails++;
      $display("FAIL R2 closes act=%0d exp>=20", m_closes);
    end
    $display("  [TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule